// File: doc/BRIEF.md
# One-Address Accumulator Processor

This block is a small sequential processor in which each instruction names at most one data-memory word. An internal accumulator is always the other source of every arithmetic operation, and it is always where the result goes. To evaluate an expression with several terms, a program must store intermediate values in data memory and load them again later. The core holds its own instruction memory and data memory. Instructions run in program-counter order from address zero. There are no jumps, and the only way to address memory is directly.

Before a run, both memories are filled through a valid/ready load stream that selects its target. A one-cycle `start` pulse then begins execution. The core raises `halted` when it reaches a halt instruction or an undefined one, and it stays halted until reset. A combinational debug port reads any data-memory word at any time, so results can be collected once the core has halted.

Load stream rules: a word is transferred on a rising clock edge when `ld_valid` and `ld_ready` are both high. `ld_ready` is high only while the core is idle, which means after reset and before `start`. While the core is running or halted, `ld_ready` is low and the producer must hold its word. Holding it has no effect on either memory.

Top module: `acc_proc`

## Requirements
- R1: After synchronous reset, `halted` and `div_err` are 0, `ld_ready` is 1 and the core is idle.
- R2: A load word is written when `ld_valid` and `ld_ready` are both high at a clock edge. `ld_target` = 0 selects instruction memory and 1 selects data memory. `ld_ready` is low whenever the core is running or halted.
- R3: An instruction word carries the opcode in bits [15:12] and the direct address in bits [11:0]. The opcodes are 0 halt, 1 load, 2 store, 3 add, 4 subtract, 5 multiply and 6 divide. An address selects the memory word at (address modulo depth).
- R4: A `start` pulse while idle starts execution at instruction address 0. Each instruction takes exactly three cycles: fetch, operand read and execute. The program counter advances by one on every fetch. If `start` is accepted at edge 0, the execute step of instruction i completes at edge 3i+3.
- R5: Load copies the addressed data word into the accumulator.
- R6: Store writes the accumulator into the addressed data word and leaves the accumulator unchanged.
- R7: Add gives acc+mem and subtract gives acc−mem, both modulo 2^16.
- R8: Multiply keeps the low 16 bits of acc×mem.
- R9: Divide gives the unsigned truncated quotient acc÷mem. A zero divisor gives 0xFFFF and sets `div_err`, which stays set until reset.
- R10: Opcode 0 and opcodes 7 to 15 halt the core. No later instruction runs, `halted` goes high at the end of that instruction's operand-read cycle and stays high until reset, and `start` is ignored while halted.
- R11: `dbg_data` shows data memory at `dbg_addr` combinationally. A store's new value appears right after its execute edge and not before.
- R12: The nine-instruction program for Y = (A−B)/(C+D·E), which uses a temporary word, stores the correct Y.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin execution from instruction 0 (idle only) |
| ld_valid | input | 1 | Load word offered |
| ld_ready | output | 1 | Load word can be accepted (idle only) |
| ld_target | input | 1 | 0 instruction memory, 1 data memory |
| ld_addr | input | 12 | Load word address |
| ld_data | input | 16 | Load word value |
| halted | output | 1 | Core has stopped; sticky until reset |
| div_err | output | 1 | Sticky divide-by-zero flag |
| dbg_addr | input | 12 | Debug read address into data memory |
| dbg_data | output | 16 | Data memory word at `dbg_addr` |

## Verification
A store's write to data memory can happen in the same cycle that the debug port is reading that same word. The bench holds `dbg_addr` on the result word of the expression program and samples `dbg_data` after every edge once `start` is accepted. It requires the old preset value after edge 23 and the quotient after edge 24, the execute edge of the final store. The same cycle count then places `halted` low after edge 25 and high after edge 26, which confirms the three-cycle sequence from outside the core.

// File: rtl/acc_pkg.sv
package acc_pkg;
  localparam int OPC_W = 4;

  localparam logic [OPC_W-1:0] OP_HALT = 4'd0;
  localparam logic [OPC_W-1:0] OP_LDA  = 4'd1;
  localparam logic [OPC_W-1:0] OP_STO  = 4'd2;
  localparam logic [OPC_W-1:0] OP_ADD  = 4'd3;
  localparam logic [OPC_W-1:0] OP_SUB  = 4'd4;
  localparam logic [OPC_W-1:0] OP_MUL  = 4'd5;
  localparam logic [OPC_W-1:0] OP_DIV  = 4'd6;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_DECODE,
    ST_EXEC,
    ST_HALT
  } core_state_e;

  function automatic logic op_is_known(input logic [OPC_W-1:0] op);
    return (op >= OP_LDA) && (op <= OP_DIV);
  endfunction

  function automatic logic op_writes_acc(input logic [OPC_W-1:0] op);
    return op_is_known(op) && (op != OP_STO);
  endfunction
endpackage

// File: rtl/acc_ram.sv
module acc_ram #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 64,
  parameter int NRD    = 1,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic                      clk,
  input  logic                      we,
  input  logic [AW-1:0]             waddr,
  input  logic [DATA_W-1:0]         wdata,
  input  logic [NRD-1:0][AW-1:0]    raddr,
  output logic [NRD-1:0][DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  for (genvar g = 0; g < NRD; g++) begin : g_rd
    assign rdata[g] = mem[raddr[g]];
  end
endmodule

// File: rtl/acc_ctrl.sv
module acc_ctrl
  import acc_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 12,
  parameter int PC_W   = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [DATA_W-1:0] instr_word,
  output logic [PC_W-1:0]   pc,
  output core_state_e       state,
  output logic [OPC_W-1:0]  opcode,
  output logic [ADDR_W-1:0] op_addr
);
  logic [DATA_W-1:0] ir;

  assign opcode  = ir[DATA_W-1 -: OPC_W];
  assign op_addr = ir[ADDR_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      pc    <= '0;
      ir    <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            pc    <= '0;
            state <= ST_FETCH;
          end
        end
        ST_FETCH: begin
          ir    <= instr_word;
          pc    <= pc + 1'b1;
          state <= ST_DECODE;
        end
        ST_DECODE: begin
          state <= op_is_known(opcode) ? ST_EXEC : ST_HALT;
        end
        ST_EXEC:  state <= ST_FETCH;
        ST_HALT:  state <= ST_HALT;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  // R4: every fetch moves to operand read and advances the counter by one
  assert_fetch_step_R4: assert property (@(posedge clk) disable iff (rst)
    (state == ST_FETCH) |=> (state == ST_DECODE && pc == PC_W'($past(pc) + 1'b1)));

  // R4: execute is always followed by the next fetch
  assert_exec_to_fetch_R4: assert property (@(posedge clk) disable iff (rst)
    (state == ST_EXEC) |=> (state == ST_FETCH));

  // R10: once stopped, the core stays stopped
  assert_halt_sticky_R10: assert property (@(posedge clk) disable iff (rst)
    (state == ST_HALT) |=> (state == ST_HALT));
endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [OPC_W-1:0]  op,
  input  logic [DATA_W-1:0] acc,
  input  logic [DATA_W-1:0] opnd,
  output logic [DATA_W-1:0] result,
  output logic              div_zero
);
  always_comb begin
    div_zero = 1'b0;
    unique case (op)
      OP_LDA: result = opnd;
      OP_ADD: result = acc + opnd;
      OP_SUB: result = acc - opnd;
      OP_MUL: result = acc * opnd;
      OP_DIV: begin
        div_zero = (opnd == '0);
        result   = div_zero ? '1 : acc / opnd;
      end
      default: result = acc;
    endcase
  end
endmodule

// File: rtl/acc_proc.sv
module acc_proc
  import acc_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int ADDR_W     = 12,
  parameter int IMEM_DEPTH = 64,
  parameter int DMEM_DEPTH = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              ld_valid,
  output logic              ld_ready,
  input  logic              ld_target,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [DATA_W-1:0] ld_data,
  output logic              halted,
  output logic              div_err,
  input  logic [ADDR_W-1:0] dbg_addr,
  output logic [DATA_W-1:0] dbg_data
);
  localparam int IAW = $clog2(IMEM_DEPTH);
  localparam int DAW = $clog2(DMEM_DEPTH);
  localparam logic [ADDR_W-1:0] IDEPTH_A = ADDR_W'(IMEM_DEPTH);
  localparam logic [ADDR_W-1:0] DDEPTH_A = ADDR_W'(DMEM_DEPTH);

  core_state_e       state;
  logic [IAW-1:0]    pc;
  logic [OPC_W-1:0]  opcode;
  logic [ADDR_W-1:0] op_addr;
  logic [DATA_W-1:0] acc, opnd, alu_res;
  logic              alu_div_zero;
  logic              ld_fire, exec_now, store_now;

  logic [0:0][IAW-1:0]    im_raddr;
  logic [0:0][DATA_W-1:0] im_rdata;
  logic [1:0][DAW-1:0]    dm_raddr;
  logic [1:0][DATA_W-1:0] dm_rdata;
  logic                   im_we, dm_we;
  logic [IAW-1:0]         im_waddr;
  logic [DAW-1:0]         dm_waddr;
  logic [DATA_W-1:0]      dm_wdata;

  assign ld_ready  = (state == ST_IDLE);
  assign halted    = (state == ST_HALT);
  assign ld_fire   = ld_valid && ld_ready;
  assign exec_now  = (state == ST_EXEC);
  assign store_now = exec_now && (opcode == OP_STO);

  // instruction memory: written by the loader, read at the program counter
  assign im_we       = ld_fire && !ld_target;
  assign im_waddr    = IAW'(ld_addr % IDEPTH_A);
  assign im_raddr[0] = pc;

  // data memory: loader or store writes; operand and debug reads
  assign dm_we       = (ld_fire && ld_target) || store_now;
  assign dm_waddr    = store_now ? DAW'(op_addr % DDEPTH_A) : DAW'(ld_addr % DDEPTH_A);
  assign dm_wdata    = store_now ? acc : ld_data;
  assign dm_raddr[0] = DAW'(op_addr % DDEPTH_A);
  assign dm_raddr[1] = DAW'(dbg_addr % DDEPTH_A);
  assign dbg_data    = dm_rdata[1];

  acc_ram #(.DATA_W(DATA_W), .DEPTH(IMEM_DEPTH), .NRD(1)) u_imem (
    .clk(clk), .we(im_we), .waddr(im_waddr), .wdata(ld_data),
    .raddr(im_raddr), .rdata(im_rdata)
  );

  acc_ram #(.DATA_W(DATA_W), .DEPTH(DMEM_DEPTH), .NRD(2)) u_dmem (
    .clk(clk), .we(dm_we), .waddr(dm_waddr), .wdata(dm_wdata),
    .raddr(dm_raddr), .rdata(dm_rdata)
  );

  acc_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .PC_W(IAW)) u_ctrl (
    .clk(clk), .rst(rst), .start(start), .instr_word(im_rdata[0]),
    .pc(pc), .state(state), .opcode(opcode), .op_addr(op_addr)
  );

  acc_alu #(.DATA_W(DATA_W)) u_alu (
    .op(opcode), .acc(acc), .opnd(opnd), .result(alu_res), .div_zero(alu_div_zero)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      acc     <= '0;
      opnd    <= '0;
      div_err <= 1'b0;
    end else begin
      if (state == ST_DECODE) opnd <= dm_rdata[0];
      if (exec_now && op_writes_acc(opcode)) acc <= alu_res;
      if (exec_now && alu_div_zero) div_err <= 1'b1;
    end
  end

  // R6: a store never disturbs the accumulator
  assert_store_keeps_acc_R6: assert property (@(posedge clk) disable iff (rst)
    store_now |=> (acc == $past(acc)));

  // R5: a load places the captured operand in the accumulator
  assert_load_copies_R5: assert property (@(posedge clk) disable iff (rst)
    (exec_now && opcode == OP_LDA) |=> (acc == $past(opnd)));

  // R9: a zero divisor saturates the quotient and raises the flag
  assert_div_zero_R9: assert property (@(posedge clk) disable iff (rst)
    (exec_now && opcode == OP_DIV && opnd == '0) |=> (acc == '1 && div_err));

  // R9: the error flag is sticky
  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    div_err |=> div_err);

  // R2: nothing is loaded once the core has left idle
  assert_no_load_busy_R2: assert property (@(posedge clk) disable iff (rst)
    (state != ST_IDLE) |-> !ld_ready);
endmodule

// File: tb/acc_proc_tb_top.sv
module acc_proc_tb_top;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst, start, ld_valid, ld_target;
  logic [11:0] ld_addr, dbg_addr;
  logic [15:0] ld_data, dbg_data;
  logic        ld_ready, halted, div_err;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cycles <= cycles + 1;

  acc_proc dut_i (
    .clk(clk), .rst(rst), .start(start),
    .ld_valid(ld_valid), .ld_ready(ld_ready), .ld_target(ld_target),
    .ld_addr(ld_addr), .ld_data(ld_data),
    .halted(halted), .div_err(div_err),
    .dbg_addr(dbg_addr), .dbg_data(dbg_data)
  );

  function automatic logic [15:0] ins(input logic [3:0] op, input logic [11:0] a);
    return {op, a};
  endfunction

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; start = 1'b0; ld_valid = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic put(input logic tgt, input logic [11:0] a, input logic [15:0] d);
    @(negedge clk);
    ld_valid = 1'b1; ld_target = tgt; ld_addr = a; ld_data = d;
    @(negedge clk);
    ld_valid = 1'b0;
  endtask

  task automatic peek(input logic [11:0] a, output logic [15:0] d);
    dbg_addr = a;
    #1;
    d = dbg_data;
  endtask

  task automatic run_to_halt();
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 400 && !halted; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 halted", {15'd0, halted}, 16'd0);
    check("R1 div_err", {15'd0, div_err}, 16'd0);
    check("R1 ld_ready", {15'd0, ld_ready}, 16'd1);
  endtask

  // R12 / R11 / R4 / R3: the full expression, with edge-exact timing
  task automatic t_expression();
    logic [15:0] v;
    do_reset();
    put(1, 1, 100); put(1, 2, 10); put(1, 3, 5); put(1, 4, 3); put(1, 5, 5);
    put(1, 7, 16'hDEAD);
    put(0, 0, ins(1, 4)); put(0, 1, ins(5, 5)); put(0, 2, ins(3, 3));
    put(0, 3, ins(2, 6)); put(0, 4, ins(1, 1)); put(0, 5, ins(4, 2));
    put(0, 6, ins(6, 6)); put(0, 7, ins(2, 7)); put(0, 8, ins(0, 0));
    dbg_addr = 12'd7;
    @(negedge clk);
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    check("R2 ld_ready low while running", {15'd0, ld_ready}, 16'd0);
    for (int k = 1; k <= 26; k++) begin
      @(posedge clk);
      @(negedge clk);
      if (k == 23) check("R11 store not yet visible", dbg_data, 16'hDEAD);
      if (k == 24) check("R11 store visible after execute edge", dbg_data, 16'd4);
      if (k == 25) check("R4 not halted before halt decode", {15'd0, halted}, 16'd0);
      if (k == 26) check("R10 halted after halt decode", {15'd0, halted}, 16'd1);
    end
    peek(7, v);  check("R12 Y result", v, 16'd4);
    peek(6, v);  check("R12 temporary C+D*E", v, 16'd20);
    peek(1, v);  check("R6 source A untouched", v, 16'd100);
    // R3: address 64+7 wraps onto word 7
    peek(12'd71, v); check("R3 address wraps modulo depth", v, 16'd4);
    check("R9 no divide error", {15'd0, div_err}, 16'd0);
  endtask

  task automatic t_wrap();
    logic [15:0] v;
    do_reset();
    put(1, 10, 300); put(1, 11, 7); put(1, 12, 5);
    put(0, 0, ins(1, 10)); put(0, 1, ins(5, 10)); put(0, 2, ins(2, 20));
    put(0, 3, ins(1, 12)); put(0, 4, ins(4, 11)); put(0, 5, ins(2, 21));
    put(0, 6, ins(3, 11)); put(0, 7, ins(2, 22)); put(0, 8, ins(0, 0));
    run_to_halt();
    peek(20, v); check("R8 multiply low half", v, 16'd24464);
    peek(21, v); check("R7 subtract wraps", v, 16'd65534);
    peek(22, v); check("R7 add wraps", v, 16'd5);
  endtask

  task automatic t_store_keep();
    logic [15:0] v;
    do_reset();
    put(1, 30, 16'h5A3C); put(1, 31, 0); put(1, 32, 0);
    put(0, 0, ins(1, 30)); put(0, 1, ins(2, 31)); put(0, 2, ins(2, 32));
    put(0, 3, ins(0, 0));
    run_to_halt();
    peek(31, v); check("R5 load then store", v, 16'h5A3C);
    peek(32, v); check("R6 accumulator kept after store", v, 16'h5A3C);
  endtask

  task automatic t_divide();
    logic [15:0] v;
    do_reset();
    put(1, 40, 9); put(1, 41, 0); put(1, 43, 50); put(1, 44, 7);
    put(0, 0, ins(1, 40)); put(0, 1, ins(6, 41)); put(0, 2, ins(2, 42));
    put(0, 3, ins(1, 43)); put(0, 4, ins(6, 44)); put(0, 5, ins(2, 45));
    put(0, 6, ins(0, 0));
    run_to_halt();
    peek(42, v); check("R9 divide by zero all ones", v, 16'hFFFF);
    peek(45, v); check("R9 truncating quotient", v, 16'd7);
    check("R9 sticky error flag", {15'd0, div_err}, 16'd1);
    do_reset();
    check("R1 reset clears error flag", {15'd0, div_err}, 16'd0);
  endtask

  task automatic t_undefined();
    logic [15:0] v;
    do_reset();
    put(1, 50, 16'h1234); put(1, 51, 0); put(1, 52, 16'hBEEF);
    put(0, 0, ins(1, 50)); put(0, 1, ins(2, 51)); put(0, 2, ins(4'hB, 0));
    put(0, 3, ins(2, 52)); put(0, 4, ins(0, 0));
    run_to_halt();
    check("R10 undefined opcode halts", {15'd0, halted}, 16'd1);
    peek(51, v); check("R10 work before halt done", v, 16'h1234);
    peek(52, v); check("R10 nothing after halt runs", v, 16'hBEEF);
    check("R2 ld_ready low while halted", {15'd0, ld_ready}, 16'd0);
    put(1, 52, 16'h0000);
    peek(52, v); check("R2 load refused while halted", v, 16'hBEEF);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (12) @(negedge clk);
    check("R10 start ignored while halted", {15'd0, halted}, 16'd1);
    peek(52, v); check("R10 no restart after start", v, 16'hBEEF);
  endtask

  initial begin
    rst = 1'b1; start = 1'b0; ld_valid = 1'b0; ld_target = 1'b0;
    ld_addr = '0; ld_data = '0; dbg_addr = '0;
    t_reset();
    t_expression();
    t_wrap();
    t_store_keep();
    t_divide();
    t_undefined();
    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    wait (cycles >= 100000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule